// File: doc/BRIEF.md
# Frame Pointer Trap Rollback Controller

This block holds the three frame pointers of a call-hardware unit (open, active and return frames) together with a shadow copy of each. A strobe marks the start of every instruction's call-hardware operation. On that strobe the shadows take the pointer values as they stood before the operation, so the shadows always describe the state before the instruction now in flight.

When a trap aborts the instructions in flight, a one-cycle trap strobe forces a rollback. The opcode-driven load enables are ignored for that cycle. The pointer input muxes switch to the shadows, every pointer clock enable is asserted, and all three pointers are restored at the end of that cycle.

The shadow bank and the header RAM share the bus that feeds the pointers. The block drives their enables so that they are never on together. After a rollback the RAM stays deselected for one full cycle, during which nothing drives the bus.

Top module: `frb_top`

## Requirements
- R1: After reset all pointers read 0, the shadow output enable and shadow source select are 0, and the RAM chip select equals the RAM request input.
- R2: Outside a trap cycle, pointer i (index 0 open, 1 active, 2 return; bits [i*PTR_W +: PTR_W] of the packed buses) takes its load value at the clock edge when its load enable is 1, and holds otherwise. Its clock enable output equals its load enable.
- R3: When the snapshot strobe is 1 outside a trap cycle, each shadow takes, at that edge, the pointer value from before the edge. This holds even when the pointer is loaded at the same edge.
- R4: In a cycle with the trap strobe at 1, the outputs change in that same cycle: the shadow output enable is 1, the shadow source select is 1, every pointer clock enable is 1, and the RAM chip select is 0.
- R5: At the edge that ends a trap cycle, every pointer takes its shadow value, and the load enables and load values of that cycle have no effect.
- R6: A snapshot strobe during a trap cycle is ignored, so the shadows keep their values.
- R7: In the cycle after a trap cycle, the RAM chip select is 0 whatever the request, and the shadow output enable is 0 unless the trap strobe is 1 again.
- R8: The shadow output enable and the RAM chip select are never 1 in the same cycle.
- R9: In a cycle that is neither a trap cycle nor the cycle after one, the shadow output enable and source select are 0 and the RAM chip select equals the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| trap_first | input | 1 | Trap strobe, high for the first cycle of trap entry |
| snap | input | 1 | Start of an instruction's call-hardware operation |
| ram_req | input | 1 | Decode request for the header RAM |
| load_en | input | NUM_PTR | Per-pointer load enable from decode |
| load_val | input | NUM_PTR*PTR_W | Per-pointer load values |
| ptr_q | output | NUM_PTR*PTR_W | Current pointer values |
| ptr_cen | output | NUM_PTR | Per-pointer clock enables |
| src_shadow | output | 1 | Pointer input muxes select the shadows |
| shadow_oe | output | 1 | Shadow bank output enable |
| hram_cs | output | 1 | Header RAM chip select |

## Verification
The enables, selects and chip select are combinational in the trap strobe, the request and one internal state bit. The bench therefore checks them in the same cycle as its stimulus, one nanosecond after driving the inputs at the falling edge. Pointer loads and restores appear one edge later, and the bench model applies them at the rising edge before the next comparison. Shadow contents are not visible at the ports. They are checked through later trap cycles, which bring the shadows out onto the pointers one edge after the strobe. The RAM blanking is checked in the cycle after each trap.

// File: rtl/frb_pkg.sv
package frb_pkg;

    // Which driver owned the shared bus in the previous cycle
    typedef enum logic {
        LAST_OTHER  = 1'b0,
        LAST_SHADOW = 1'b1
    } last_drv_e;

    typedef struct packed {
        last_drv_e last;
    } drv_state_t;

endpackage

// File: rtl/frb_drive_ctl.sv
module frb_drive_ctl
    import frb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trap_first,
    input  logic ram_req,
    output logic shadow_oe,
    output logic hram_cs,
    output logic src_shadow
);

    drv_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.last  = trap_first ? LAST_SHADOW : LAST_OTHER;
        shadow_oe  = trap_first;
        src_shadow = trap_first;
        // RAM waits one whole cycle after the shadows released the bus
        hram_cs    = ram_req && !trap_first && (st_q.last != LAST_SHADOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: LAST_OTHER};
        else        st_q <= st_d;
    end

    // R8
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shadow_oe && hram_cs));

    // R7
    ram_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_first |=> !hram_cs);

endmodule

// File: rtl/frb_shadow_bank.sv
module frb_shadow_bank #(
    parameter int PTR_W   = 8,
    parameter int NUM_PTR = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            snap,
    input  logic                            trap_first,
    input  logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_cur,
    output logic [NUM_PTR-1:0][PTR_W-1:0]   shadow
);

    typedef struct packed {
        logic [NUM_PTR-1:0][PTR_W-1:0] val;
    } shd_t;

    shd_t shd_d, shd_q;
    logic take;

    always_comb begin
        take  = snap && !trap_first;
        shd_d = shd_q;
        if (take) shd_d.val = ptr_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign shadow = shd_q.val;

    // R3
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && !trap_first) |=> (shadow == $past(ptr_cur)));

    // R6
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_first |=> $stable(shadow));

endmodule

// File: rtl/frb_ptr_file.sv
module frb_ptr_file #(
    parameter int PTR_W   = 8,
    parameter int NUM_PTR = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            use_shadow,
    input  logic [NUM_PTR-1:0]              load_en,
    input  logic [NUM_PTR-1:0][PTR_W-1:0]   load_val,
    input  logic [NUM_PTR-1:0][PTR_W-1:0]   shadow,
    output logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_q,
    output logic [NUM_PTR-1:0]              ptr_cen
);

    typedef struct packed {
        logic [NUM_PTR-1:0][PTR_W-1:0] val;
    } ptr_t;

    ptr_t pf_d, pf_q;
    logic [NUM_PTR-1:0][PTR_W-1:0] mux_in;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_comb begin
            mux_in[i]  = use_shadow ? shadow[i] : load_val[i];
            ptr_cen[i] = use_shadow || load_en[i];
        end
    end

    always_comb begin
        pf_d = pf_q;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (ptr_cen[i]) pf_d.val[i] = mux_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pf_q <= '0;
        else        pf_q <= pf_d;
    end

    assign ptr_q = pf_q.val;

    // R4
    all_cen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_shadow |-> (ptr_cen == '1));

    // R5
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_shadow |=> (ptr_q == $past(shadow)));

endmodule

// File: rtl/frb_top.sv
module frb_top #(
    parameter int PTR_W   = 8,
    parameter int NUM_PTR = 3,
    localparam int BUS_W  = NUM_PTR * PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_first,
    input  logic                snap,
    input  logic                ram_req,
    input  logic [NUM_PTR-1:0]  load_en,
    input  logic [BUS_W-1:0]    load_val,
    output logic [BUS_W-1:0]    ptr_q,
    output logic [NUM_PTR-1:0]  ptr_cen,
    output logic                src_shadow,
    output logic                shadow_oe,
    output logic                hram_cs
);

    logic [NUM_PTR-1:0][PTR_W-1:0] val_a, ptr_a, shd_a;

    assign val_a = load_val;
    assign ptr_q = ptr_a;

    frb_drive_ctl u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_first (trap_first),
        .ram_req    (ram_req),
        .shadow_oe  (shadow_oe),
        .hram_cs    (hram_cs),
        .src_shadow (src_shadow)
    );

    frb_shadow_bank #(.PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_shd (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap       (snap),
        .trap_first (trap_first),
        .ptr_cur    (ptr_a),
        .shadow     (shd_a)
    );

    frb_ptr_file #(.PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_shadow (src_shadow),
        .load_en    (load_en),
        .load_val   (val_a),
        .shadow     (shd_a),
        .ptr_q      (ptr_a),
        .ptr_cen    (ptr_cen)
    );

    // R9
    idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_first |-> (!shadow_oe && !src_shadow));

endmodule

// File: tb/frb_top_tb_top.sv
module frb_top_tb_top;
    localparam int W = 8;
    localparam int N = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic trap_first = 0, snap = 0, ram_req = 0;
    logic [N-1:0] load_en = '0;
    logic [N*W-1:0] load_val = '0;
    logic [N*W-1:0] ptr_q;
    logic [N-1:0] ptr_cen;
    logic src_shadow, shadow_oe, hram_cs;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    int m_ptr[N];
    int m_shd[N];
    bit m_last_trap = 0;
    string ptr_tag = "R1";

    always #2 clk = ~clk;

    frb_top #(.PTR_W(W), .NUM_PTR(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_first(trap_first), .snap(snap),
        .ram_req(ram_req), .load_en(load_en), .load_val(load_val),
        .ptr_q(ptr_q), .ptr_cen(ptr_cen), .src_shadow(src_shadow),
        .shadow_oe(shadow_oe), .hram_cs(hram_cs));

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit tr, bit sn, bit rq, logic [N-1:0] en, logic [N*W-1:0] v);
        bit exp_cs;
        @(negedge clk);
        trap_first = tr; snap = sn; ram_req = rq; load_en = en; load_val = v;
        #1;
        for (int i = 0; i < N; i++) chk(ptr_tag, int'(ptr_q[i*W +: W]), m_ptr[i]);
        exp_cs = rq && !tr && !m_last_trap;
        if (tr) begin
            chk("R4 oe", shadow_oe, 1); chk("R4 sel", src_shadow, 1);
            chk("R4 cen", int'(ptr_cen), (1 << N) - 1); chk("R4 cs", hram_cs, 0);
        end else if (m_last_trap) begin
            chk("R7 cs", hram_cs, 0); chk("R7 oe", shadow_oe, 0);
            chk("R2 cen", int'(ptr_cen), int'(en));
        end else begin
            chk("R9 oe", shadow_oe, 0); chk("R9 sel", src_shadow, 0);
            chk("R9 cs", hram_cs, int'(exp_cs));
            chk("R2 cen", int'(ptr_cen), int'(en));
        end
        chk("R8 clash", int'(shadow_oe && hram_cs), 0);
        @(posedge clk);
        begin
            int old[N];
            for (int i = 0; i < N; i++) old[i] = m_ptr[i];
            for (int i = 0; i < N; i++) begin
                if (tr) m_ptr[i] = m_shd[i];
                else if (en[i]) m_ptr[i] = int'(v[i*W +: W]);
            end
            if (sn && !tr) for (int i = 0; i < N; i++) m_shd[i] = old[i];
        end
        ptr_tag = tr ? "R3 R5 R6 restore" : "R2 load";
        m_last_trap = tr;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_ptr[i] = 0; m_shd[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; ram_req = 1; #1;
        for (int i = 0; i < N; i++) chk("R1 ptr", int'(ptr_q[i*W +: W]), 0);
        chk("R1 oe", shadow_oe, 0); chk("R1 sel", src_shadow, 0); chk("R1 cs", hram_cs, 1);
        // directed: load, snapshot with simultaneous load, trap restore
        step(0, 0, 1, 3'b111, {8'd30, 8'd20, 8'd10});
        step(0, 1, 1, 3'b011, {8'd99, 8'd21, 8'd11});
        step(0, 0, 1, 3'b100, {8'd31, 8'd0, 8'd0});
        step(1, 1, 1, 3'b111, {8'd5, 8'd5, 8'd5});     // R5 loads ignored, R6 snap ignored
        step(0, 0, 1, 3'b000, '0);                      // R7 gap
        step(1, 0, 1, 3'b010, {8'd1, 8'd2, 8'd3});      // back-to-back trap from old shadows
        step(0, 0, 1, 3'b000, '0);
        step(0, 0, 1, 3'b000, '0);
        for (int k = 0; k < 600; k++) begin
            bit tr = ($urandom_range(0, 6) == 0) && !m_last_trap;
            if ($urandom_range(0, 9) == 0) tr = 1;
            step(tr, 1'($urandom), 1'($urandom), 3'($urandom), 24'($urandom));
        end
        step(0, 0, 0, 3'b000, '0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule